// File: doc/BRIEF.md
# Gated Serial Clock Divider

This block derives the serial flash clock from the functional clock (nominally 192 MHz) by integer division. A single memory-mapped control register holds an enable flag and a 16-bit divide value D. While the flag is set and the transfer engine reports an active transfer, the block emits a one-cycle strobe every D+1 functional clock cycles. It also drives a serial clock level that toggles on each strobe and rests at a pin-selected idle level whenever the divider is stopped.

Software reprograms the divider in two writes. The first clears the enable flag. The second loads the new divide value with the flag set again. Every accepted write to the control register clears the counter and the phase, so the divider always restarts from its idle phase. The first strobe after any restart comes D+1 cycles after counting resumes. When D is 0, the strobe is high on every cycle and the serial clock level does not toggle. Downstream shift logic then treats the strobe as a plain clock enable.

Top module: `sclk_divider`

## Requirements
- R1: After reset the enable flag and divide value are 0, `sclk_tick` is 0 and `sclk` equals `sclk_idle_pol`.
- R2: A write with `wr_en` high and `wr_addr` equal to the control offset (default 0x40) loads bit 31 as the enable flag and bits 15:0 as D. A write to any other offset leaves the divider state unchanged.
- R3: While the enable flag is 0, `sclk_tick` stays 0 and `sclk` stays at the idle level.
- R4: While `xfer_active` is low, the counter is held cleared and `sclk` is idle. After `xfer_active` rises, the first strobe comes D+1 cycles later.
- R5: While running with D > 0, `sclk_tick` is a single-cycle pulse repeating every D+1 cycles. The first pulse follows D+1 cycles after counting starts.
- R6: With D > 0, `sclk` inverts on each strobe, so its period is 2(D+1) cycles. Its first transition leaves the idle level.
- R7: With D = 0 and running, `sclk_tick` is high on every cycle and `sclk` stays at the idle level.
- R8: Any accepted control write clears the counter and phase in the cycle of the write, even in mid-period. `sclk` returns to idle and the next strobe follows D+1 cycles after the write.
- R9: `sclk` equals `sclk_idle_pol` XOR the internal phase, so either idle level can be selected.
- R10: D = 0xFFFF gives a strobe interval of 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| xfer_active | input | 1 | Transfer engine running qualifier |
| sclk_idle_pol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock level |
| sclk_tick | output | 1 | Divided clock-enable strobe |

## Verification
The bench counts cycles to the first strobe after a write, after `xfer_active` rises, and after a write in mid-period. A counter that does not restart, or that is off by one in its compare, gives an interval of D or D+2, or a short first period. Divide-by-one is checked for a continuous strobe with a still `sclk`, which a design that toggled at D = 0 would fail. The largest divide value is timed in full to catch a truncated counter. Ignored writes to another offset and the inverted idle level are observed directly on `sclk` and `sclk_tick`.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
  localparam int DIV_W_DEF    = 16;
  localparam int ADDR_W_DEF   = 8;
  localparam int DATA_W_DEF   = 32;
  localparam int EN_POS_DEF   = 31;
  localparam int CTRL_OFS_DEF = 'h40;
endpackage

// File: rtl/sclkdiv_ctrl.sv
module sclkdiv_ctrl #(
  parameter int ADDR_W = sclkdiv_pkg::ADDR_W_DEF,
  parameter int DATA_W = sclkdiv_pkg::DATA_W_DEF,
  parameter int DIV_W  = sclkdiv_pkg::DIV_W_DEF,
  parameter int EN_POS = sclkdiv_pkg::EN_POS_DEF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(sclkdiv_pkg::CTRL_OFS_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              restart
);
  logic hit;
  assign hit     = wr_en && (wr_addr == CTRL_ADDR);
  assign restart = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (hit) begin
      en_q  <= wr_data[EN_POS];
      div_q <= wr_data[DIV_W-1:0];
    end
  end

  // R2: state only moves on an accepted write
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(div_q) && $stable(en_q)));
endmodule

// File: rtl/sclkdiv_count.sv
module sclkdiv_count #(
  parameter int DIV_W = sclkdiv_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             xfer_active,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick_q,
  output logic             phase_q
);
  logic [DIV_W-1:0] cnt_q;
  logic             run;
  logic             wrap;

  assign run  = en && xfer_active && !restart;
  assign wrap = (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tick_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      tick_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      tick_q  <= 1'b1;
      phase_q <= (div == '0) ? phase_q : ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      tick_q  <= 1'b0;
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div);
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && div != '0) |=> !tick_q);
  p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && xfer_active) |=> (!tick_q && !phase_q));
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick_q && !phase_q && cnt_q == '0));
  p_d0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div == '0) |=> (tick_q && $stable(phase_q)));
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q) |-> tick_q);
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int ADDR_W = sclkdiv_pkg::ADDR_W_DEF,
  parameter int DATA_W = sclkdiv_pkg::DATA_W_DEF,
  parameter int DIV_W  = sclkdiv_pkg::DIV_W_DEF,
  parameter int EN_POS = sclkdiv_pkg::EN_POS_DEF,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(sclkdiv_pkg::CTRL_OFS_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer_active,
  input  logic              sclk_idle_pol,
  output logic              sclk,
  output logic              sclk_tick
);
  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;
  logic             phase_q;

  sclkdiv_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .EN_POS(EN_POS), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_q(en_q), .div_q(div_q), .restart(restart)
  );

  sclkdiv_count #(.DIV_W(DIV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en_q), .xfer_active(xfer_active),
    .restart(restart), .div(div_q), .tick_q(sclk_tick), .phase_q(phase_q)
  );

  assign sclk = sclk_idle_pol ^ phase_q;

  // R9: a stopped divider rests at the selected level
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (sclk == sclk_idle_pol));
endmodule

// File: tb/sim_sclk_divider.sv
module sim_sclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        xfer_active = 1'b0;
  logic        sclk_idle_pol = 1'b0;
  logic        sclk;
  logic        sclk_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer_active(xfer_active),
    .sclk_idle_pol(sclk_idle_pol), .sclk(sclk), .sclk_tick(sclk_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (sclk_tick) begin n = i; break; end
    end
  endtask

  task automatic set_div(input int d);
    wr(8'h40, 32'h0);
    wr(8'h40, 32'h8000_0000 | d);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sclk_tick == 1'b0, "R1 tick", sclk_tick, 0);
    chk(sclk == sclk_idle_pol, "R1 sclk", sclk, sclk_idle_pol);
  endtask

  task automatic t_basic;
    int n;
    xfer_active = 1'b1;
    set_div(4);
    wait_tick(20, n);
    chk(n == 5, "R5 first interval", n, 5);
    chk(sclk == 1'b1, "R6 first edge leaves idle", sclk, 1);
    wait_tick(20, n);
    chk(n == 5, "R5 period", n, 5);
    chk(sclk == 1'b0, "R6 second edge", sclk, 0);
    @(negedge clk);
    chk(sclk_tick == 1'b0, "R5 single cycle", sclk_tick, 0);
    set_div(1);
    wait_tick(20, n);
    chk(n == 2, "R2 new divide loaded", n, 2);
  endtask

  task automatic t_d0;
    int n;
    int cnt = 0;
    set_div(0);
    wait_tick(5, n);
    chk(n == 1, "R7 first", n, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sclk_tick && sclk == sclk_idle_pol) cnt++;
    end
    chk(cnt == 6, "R7 continuous strobe, still sclk", cnt, 6);
  endtask

  task automatic t_disable;
    int cnt = 0;
    wr(8'h40, 32'h0000_0003);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sclk_tick || sclk != sclk_idle_pol) cnt++;
    end
    chk(cnt == 0, "R3 disabled stays idle", cnt, 0);
  endtask

  task automatic t_badaddr;
    int cnt = 0;
    wr(8'h44, 32'h8000_0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (sclk_tick) cnt++;
    end
    chk(cnt == 0, "R2 other offset ignored", cnt, 0);
  endtask

  task automatic t_xfer;
    int n;
    set_div(3);
    wait_tick(20, n);
    @(negedge clk);
    xfer_active = 1'b0;
    @(negedge clk);
    chk(sclk == sclk_idle_pol && !sclk_tick, "R4 held idle", sclk, sclk_idle_pol);
    repeat (3) @(negedge clk);
    xfer_active = 1'b1;
    wait_tick(20, n);
    chk(n == 4, "R4 restart interval", n, 4);
  endtask

  task automatic t_restart;
    int n;
    set_div(9);
    wait_tick(30, n);
    repeat (5) @(negedge clk);
    chk(sclk == 1'b1, "R8 mid-period high", sclk, 1);
    wr(8'h40, 32'h8000_0009);
    chk(sclk == sclk_idle_pol, "R8 idle after write", sclk, sclk_idle_pol);
    wait_tick(30, n);
    chk(n == 10, "R8 full interval after write", n, 10);
  endtask

  task automatic t_pol;
    int n;
    sclk_idle_pol = 1'b1;
    wr(8'h40, 32'h0);
    @(negedge clk);
    chk(sclk == 1'b1, "R9 inverted idle", sclk, 1);
    wr(8'h40, 32'h8000_0002);
    wait_tick(20, n);
    chk(sclk == 1'b0, "R9 first edge from high idle", sclk, 0);
    sclk_idle_pol = 1'b0;
  endtask

  task automatic t_max;
    int n;
    set_div(32'hFFFF);
    wait_tick(70000, n);
    chk(n == 65536, "R10 max divide", n, 65536);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_d0();
    t_disable();
    t_badaddr();
    t_xfer();
    t_restart();
    t_pol();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule